// File: doc/BRIEF.md
# Glitch-Free Selectable Clock Divider Bank

This block derives three banks of divided clocks (A, B and C) from one fast source clock. Each bank has a 2-bit ratio code of its own, and a shared range bit either keeps the bank's base ratio or doubles it. Doubling every ratio together keeps the frequency relationships between banks unchanged. Every ratio is even, so each output has an exact 50% duty cycle. Each bank fans out to four outputs. The upper two outputs of bank C can be inverted by a control input.

Ratio codes and the range bit may change at any time while the block runs. The change is registered and applied only at the start of an output period. The period in progress always finishes at its old length, so no output period is ever shorter or longer than both the old and the new period. When a bank starts a period with a ratio that differs from its previous one, the block pulses an update flag for one cycle. All banks leave reset aligned, so their first rising edges fall on the same source cycle.

Top module: `clkdiv_bank`

## Requirements
- R1: While `rst_n` is low, every clock output and every `ratio_upd` bit is 0. On the first source cycle after release, all three banks rise together.
- R2: With `range_hi`=1, bank A divides by 4, 6, 8 and 12 for `sel_a` codes 0, 1, 2 and 3.
- R3: With `range_hi`=1, bank B divides by 4, 6, 8 and 10 for `sel_b` codes 0, 1, 2 and 3.
- R4: With `range_hi`=1, bank C divides by 2, 4, 6 and 8 for `sel_c` codes 0, 1, 2 and 3.
- R5: With `range_hi`=0, each bank's ratio is twice its `range_hi`=1 value.
- R6: Each output is high for exactly half of every period and low for the other half.
- R7: Codes and the range bit are registered on the source clock. The ratio of a period is the one given by the inputs present one edge before the edge at which that period's rising edge occurs. A period in progress always completes at its own ratio, whatever the inputs do.
- R8: `ratio_upd` bit 0 (A), bit 1 (B) or bit 2 (C) is high for exactly the one cycle in which that bank rises with a ratio different from its previous period. It never pulses on the first rise after reset.
- R9: The four outputs of bank A are always equal, the four outputs of bank B are always equal, and `qc[1]` always equals `qc[0]`.
- R10: `qc[3]` and `qc[2]` equal `qc[0]` XOR the value of `inv_en` sampled at the previous source edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sel_a | input | 2 | Bank A ratio code |
| sel_b | input | 2 | Bank B ratio code |
| sel_c | input | 2 | Bank C ratio code |
| range_hi | input | 1 | 1 = base ratios, 0 = doubled ratios |
| inv_en | input | 1 | Inverts qc[3:2] when high |
| qa | output | 4 | Bank A clock outputs |
| qb | output | 4 | Bank B clock outputs |
| qc | output | 4 | Bank C clock outputs |
| ratio_upd | output | 3 | One-cycle pulse per bank when a new ratio takes effect |

## Verification
Long directed holds on each code under both range settings measure every full period and every high phase. This separates the ratio tables of the three banks and confirms the doubling. Sparse random changes of codes, range and inversion land at arbitrary phases of a period, which shows whether a change leaks into a period already running. A burst where the inputs change on every cycle shows whether the ratio is taken from the correct registered sample rather than from a neighbouring one. Fanout equality, the inversion and the update pulse are compared on every cycle, so a stray pulse or a skewed output is caught in any phase.

// File: rtl/clkdiv_pkg.sv
// Package: shared constants and ratio lookup for the divider bank.
// Assumes bank indices 0 = A, 1 = B, 2 = C.
package clkdiv_pkg;
    localparam int NBANK  = 3;
    localparam int HALF_W = 4;

    typedef logic [HALF_W-1:0] half_t;

    // Half-period, in source cycles, for a bank, code and range setting.
    function automatic half_t half_for(input int bank, input logic [1:0] code, input logic rng);
        half_t b;
        case (bank)
            0: case (code)
                   2'd0: b = half_t'(2);
                   2'd1: b = half_t'(3);
                   2'd2: b = half_t'(4);
                   default: b = half_t'(6);
               endcase
            1: case (code)
                   2'd0: b = half_t'(2);
                   2'd1: b = half_t'(3);
                   2'd2: b = half_t'(4);
                   default: b = half_t'(5);
               endcase
            default: case (code)
                   2'd0: b = half_t'(1);
                   2'd1: b = half_t'(2);
                   2'd2: b = half_t'(3);
                   default: b = half_t'(4);
               endcase
        endcase
        return rng ? b : half_t'(b << 1);
    endfunction
endpackage

// File: rtl/clkdiv_chan.sv
// Module: one divider channel. Registers its code and range, and toggles
// an output every half-period. A new half-period is loaded only when the
// output rises, so a running period always ends at its own length.
// Assumes: synchronous active-low reset; bank index picks the ratio table.
module clkdiv_chan
    import clkdiv_pkg::*;
#(
    parameter int BANK = 0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] code,
    input  logic       rng,
    output logic       q,
    output logic       upd
);
    logic [1:0] code_q;
    logic       rng_q;
    half_t      half_r;
    half_t      cnt;
    half_t      new_half;

    // Capture the ratio inputs on the source clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= 2'b00;
            rng_q  <= 1'b1;
        end else begin
            code_q <= code;
            rng_q  <= rng;
        end
    end

    // Ratio that a period starting now would use.
    always_comb new_half = half_for(BANK, code_q, rng_q);

    // Phase counter: toggles the output and loads a ratio only at a rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q      <= 1'b0;
            cnt    <= half_t'(1);
            half_r <= '0;
            upd    <= 1'b0;
        end else begin
            upd <= 1'b0;
            if (cnt == half_t'(1)) begin
                q <= ~q;
                if (!q) begin
                    half_r <= new_half;
                    cnt    <= new_half;
                    upd    <= (half_r != '0) && (new_half != half_r);
                end else begin
                    cnt <= half_r;
                end
            end else begin
                cnt <= cnt - half_t'(1);
            end
        end
    end
endmodule

// File: rtl/clkdiv_fanout.sv
// Module: replicates one channel clock onto N outputs. The top NINV
// outputs are XORed with a registered invert bit, so every output
// leaves the same flop through one gate level.
module clkdiv_fanout #(
    parameter int NOUT = 4,
    parameter int NINV = 0
) (
    input  logic            q,
    input  logic            inv,
    output logic [NOUT-1:0] y
);
    generate
        for (genvar i = 0; i < NOUT; i++) begin : g_out
            localparam bit MASK = (i >= NOUT - NINV);
            // Drive output i, inverted only when it is in the masked group.
            assign y[i] = q ^ (inv & MASK);
        end
    endgenerate
endmodule

// File: rtl/clkdiv_bank.sv
// Module: top of the three-bank divider. One channel per bank, each
// feeding a fanout stage; bank C's upper outputs can be inverted.
// Assumes all inputs are synchronous to clk.
module clkdiv_bank
    import clkdiv_pkg::*;
#(
    parameter int NOUT = 4,
    parameter int NINV = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      sel_a,
    input  logic [1:0]      sel_b,
    input  logic [1:0]      sel_c,
    input  logic            range_hi,
    input  logic            inv_en,
    output logic [NOUT-1:0] qa,
    output logic [NOUT-1:0] qb,
    output logic [NOUT-1:0] qc,
    output logic [NBANK-1:0] ratio_upd
);
    logic [1:0]      sel_v [NBANK];
    logic [NBANK-1:0] bank_q;
    logic [NOUT-1:0] y_v   [NBANK];
    logic            inv_q;

    assign sel_v[0] = sel_a;
    assign sel_v[1] = sel_b;
    assign sel_v[2] = sel_c;

    // Register the invert control so it lines up with the channel flops.
    always_ff @(posedge clk) begin
        if (!rst_n) inv_q <= 1'b0;
        else        inv_q <= inv_en;
    end

    generate
        for (genvar k = 0; k < NBANK; k++) begin : g_bank
            clkdiv_chan #(.BANK(k)) u_chan (
                .clk  (clk),
                .rst_n(rst_n),
                .code (sel_v[k]),
                .rng  (range_hi),
                .q    (bank_q[k]),
                .upd  (ratio_upd[k])
            );
            clkdiv_fanout #(.NOUT(NOUT), .NINV((k == NBANK - 1) ? NINV : 0)) u_fan (
                .q  (bank_q[k]),
                .inv(inv_q),
                .y  (y_v[k])
            );
        end
    endgenerate

    assign qa = y_v[0];
    assign qb = y_v[1];
    assign qc = y_v[2];
endmodule

// File: rtl/clkdiv_bank_chk.sv
// Checker: temporal properties on the divider bank ports.
module clkdiv_bank_chk #(
    parameter int MAX_HALF = 12
) (
    input logic       clk,
    input logic       rst_n,
    input logic       inv_en,
    input logic [3:0] qa,
    input logic [3:0] qb,
    input logic [3:0] qc,
    input logic [2:0] ratio_upd
);
    int hi_run;

    // Count consecutive high cycles of bank A.
    always_ff @(posedge clk) begin
        if (!rst_n)     hi_run <= 0;
        else if (qa[0]) hi_run <= hi_run + 1;
        else            hi_run <= 0;
    end

    p_align_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(rst_n, 2) && $past(rst_n)) |-> (qa[0] && qb[0] && qc[0]));

    p_updrise_a_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ratio_upd[0] |-> $rose(qa[0]));

    p_updrise_c_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ratio_upd[2] |-> $rose(qc[0]));

    p_fanout_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (qa == {4{qa[0]}}) && (qb == {4{qb[0]}}) && (qc[1] == qc[0]));

    p_invert_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (qc[3:2] == {2{qc[0] ^ $past(inv_en)}}));

    p_run_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        hi_run <= MAX_HALF);
endmodule

bind clkdiv_bank clkdiv_bank_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .inv_en   (inv_en),
    .qa       (qa),
    .qb       (qb),
    .qc       (qc),
    .ratio_upd(ratio_upd)
);

// File: tb/clkdiv_bank_tb.sv
module clkdiv_bank_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] sel_a = 2'd0, sel_b = 2'd0, sel_c = 2'd0;
    logic       range_hi = 1'b1, inv_en = 1'b0;
    logic [3:0] qa, qb, qc;
    logic [2:0] ratio_upd;

    int total = 0, bad = 0, cyc = 0;
    bit done = 0;

    // History of applied inputs: {sel_a, sel_b, sel_c, range, inv}
    logic [7:0] h1 = 8'b00_00_00_1_0, h2 = 8'b00_00_00_1_0;
    int since [3];
    int exp_per [3];
    bit seen [3];
    bit pq [3];

    always #2.5 clk = ~clk;

    clkdiv_bank u_dut (.clk(clk), .rst_n(rst_n), .sel_a(sel_a), .sel_b(sel_b),
        .sel_c(sel_c), .range_hi(range_hi), .inv_en(inv_en), .qa(qa), .qb(qb),
        .qc(qc), .ratio_upd(ratio_upd));

    function automatic int ref_ratio(input int b, input logic [1:0] c, input logic rng);
        int r;
        if (b == 0)      r = (c == 0) ? 4 : (c == 1) ? 6 : (c == 2) ? 8 : 12;
        else if (b == 1) r = (c == 0) ? 4 : (c == 1) ? 6 : (c == 2) ? 8 : 10;
        else             r = (c == 0) ? 2 : (c == 1) ? 4 : (c == 2) ? 6 : 8;
        return rng ? r : 2 * r;
    endfunction

    function automatic logic [1:0] code_of(input logic [7:0] h, input int b);
        return (b == 0) ? h[7:6] : (b == 1) ? h[5:4] : h[3:2];
    endfunction

    function automatic string tag(input int b, input logic rng);
        string t;
        t = (b == 0) ? "R2" : (b == 1) ? "R3" : "R4";
        return rng ? t : {t, "/R5"};
    endfunction

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // Sample outputs at a negedge and compare with the expected behaviour.
    task automatic sample();
        logic qv [3];
        bit   rise, fall, want_upd;
        int   np;
        qv[0] = qa[0]; qv[1] = qb[0]; qv[2] = qc[0];
        for (int b = 0; b < 3; b++) begin
            since[b]++;
            rise = qv[b] && !pq[b];
            fall = !qv[b] && pq[b];
            np = ref_ratio(b, code_of(h2, b), h2[1]);
            want_upd = 0;
            if (rise && seen[b]) begin
                chk(since[b] == exp_per[b], {tag(b, h2[1]), " R7 period"}, since[b], exp_per[b]);
                want_upd = (np != exp_per[b]);
            end
            if (fall && seen[b])
                chk(since[b] * 2 == exp_per[b], "R6 high phase", since[b], exp_per[b] / 2);
            chk(ratio_upd[b] == want_upd, "R8 update pulse", ratio_upd[b], want_upd);
            if (rise) begin
                since[b] = 0;
                exp_per[b] = np;
                seen[b] = 1;
            end
            pq[b] = qv[b];
        end
        chk(qa == {4{qa[0]}} && qb == {4{qb[0]}} && qc[1] == qc[0], "R9 fanout", {qa, qb, qc}, 0);
        chk(qc[3:2] == {2{qc[0] ^ h1[0]}}, "R10 inversion", qc[3:2], {2{qc[0] ^ h1[0]}});
    endtask

    // Advance one cycle: sample, then apply new inputs.
    task automatic step(input logic [7:0] nv);
        @(negedge clk);
        cyc++;
        sample();
        h2 = h1;
        {sel_a, sel_b, sel_c, range_hi, inv_en} = nv;
        h1 = nv;
    endtask

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired act=%0d exp=0", cyc);
        finish_run();
    end

    initial begin
        logic [7:0] cur;
        void'($urandom(32'd1234));
        for (int b = 0; b < 3; b++) begin
            since[b] = 0; exp_per[b] = 0; seen[b] = 0; pq[b] = 0;
        end
        // R1: reset state.
        repeat (4) begin
            @(negedge clk);
            chk(qa == 0 && qb == 0 && qc == 0 && ratio_upd == 0, "R1 reset outputs", {qa, qb, qc}, 0);
        end
        rst_n = 1'b1;
        cur = 8'b00_00_00_1_0;
        @(negedge clk);
        chk(qa[0] && qb[0] && qc[0], "R1 aligned first rise", {qa[0], qb[0], qc[0]}, 7);
        sample();
        repeat (40) step(cur);
        // Directed: every code under both ranges (R2 R3 R4 R5).
        for (int r = 1; r >= 0; r--) begin
            for (int c = 0; c < 4; c++) begin
                cur = {c[1:0], c[1:0], c[1:0], r[0], 1'b0};
                repeat (80) step(cur);
            end
        end
        // Random changes at arbitrary phases (R7 R10).
        for (int i = 0; i < 3000; i++) begin
            if ($urandom % 12 == 0) cur = 8'($urandom);
            step(cur);
        end
        // Corner: inputs change every cycle (R7).
        for (int i = 0; i < 60; i++) begin
            cur = 8'($urandom);
            step(cur);
        end
        repeat (60) step(cur);
        finish_run();
    end
endmodule